// File: doc/BRIEF.md
# Stream ID Match and Routing Unit

This block sorts incoming bus transactions by their 10-bit stream ID. All transactions that carry the same ID are handled the same way. Each request is compared in one cycle against a bank of programmable match entries. A single hit selects the routing entry paired with the matching entry. That routing entry decides whether the transaction faults, passes through untranslated, or is sent to a numbered context bank. When nothing matches, a global control picks bypass or fault. When two or more entries match, the transaction always faults and the fault is marked imprecise. A faulted transaction is reported either as a bus abort or as read-as-zero/write-ignored, depending on a global enable bit.

The bank is divided into two sets by a split index. Entries with an index below the split belong to the non-secure set. Entries at or above the split belong to the secure set. The security state of a request decides which set is searched. Configuration arrives on a simple write port that carries a security attribute. A non-secure access can change only the non-secure entries. The global controls and the split index can be changed only by secure accesses.

Top module: `sid_route_unit`

## Requirements
- R1: After reset all result outputs are 0, every match entry is invalid, the split index is 0, and both global control bits are 0. A request on the reset configuration therefore produces RAZ/WI with a hit count of 0.
- R2: A match entry hits when its valid bit is 1, it lies in the searched set, and `((sid ^ id) & ~mask) == 0`. A mask bit of 1 removes that ID bit from the comparison. A cleared valid bit never hits.
- R3: On exactly one hit, the paired routing type decides the action. The type encodings are 0 = fault, 1 = bypass, 2 = translate, and the reserved value 3 is treated as fault.
- R4: `res_cb_o` carries the routing entry's context bank index only when the action is translate. For every other action it is 0.
- R5: With no hit, the action is bypass if control bit 1 (miss-bypass) is set. Otherwise the transaction faults.
- R6: With two or more hits, the transaction faults and `res_imprecise_o` is 1. `res_hits_o` counts the hits and saturates at 2, so it is 0, 1 or 2 and never 3. `res_imprecise_o` is 0 in every other case.
- R7: A faulted transaction reports action 2 (abort) if control bit 0 (abort-enable) is set, and action 3 (RAZ/WI) if it is clear. The non-fault actions are 0 = bypass and 1 = translate.
- R8: A non-secure request searches only entries with index < split. A secure request searches only entries with index >= split. A split of 0 makes every entry secure, and a split of 16 or more makes every entry non-secure.
- R9: A non-secure write to a match or routing entry whose index is >= split is dropped. A non-secure write to the control register or to the split register is also dropped. Secure writes are always accepted.
- R10: The result appears on the cycle after the request is sampled. In any cycle with no result, `res_valid_o` is 0 and every result field is 0. A write that lands on the same edge as a request affects only later requests.
- R11: Register map for N entries, with data packed LSB first. Address n < N is a match entry: bit 31 = valid, bits [25:16] = mask, bits [9:0] = ID. Address N+n is a routing entry: bits [1:0] = type, bits [13:8] = context bank. Address 2N is the control register: bit 0 = abort-enable, bit 1 = miss-bypass. Address 2N+1 is the split register: bits [4:0] = split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_secure_i | input | 1 | Write comes from a secure access |
| cfg_addr_i | input | 6 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Transaction request valid |
| req_secure_i | input | 1 | Transaction security state (1 = secure) |
| req_sid_i | input | 10 | Transaction stream ID |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_action_o | output | 2 | 0 bypass, 1 translate, 2 abort, 3 RAZ/WI |
| res_cb_o | output | 6 | Selected context bank on translate, else 0 |
| res_imprecise_o | output | 1 | Multiple-hit fault flag |
| res_hits_o | output | 2 | Hit count saturating at 2 |

## Verification
The bench builds the block with its defaults: 16 entries, 10-bit IDs and 6-bit context bank indices. With 16 entries and a 5-bit split, the bench can reach the split values 0 and 16, values above 16, and a mid-bank split of 8. It can also write at the exact edge of the partition. The directed phase drives overlapping masks into the multiple-hit and saturation path. A randomized phase then draws IDs from a small range, so single, double and triple hits recur often. Writes land on the same edge as requests and across the partition boundary in both security states.

// File: rtl/sid_route_pkg.sv
package sid_route_pkg;

  typedef enum logic [1:0] {
    RT_FAULT  = 2'd0,
    RT_BYPASS = 2'd1,
    RT_XLATE  = 2'd2,
    RT_RSVD   = 2'd3
  } route_type_e;

  typedef enum logic [1:0] {
    ACT_BYPASS = 2'd0,
    ACT_XLATE  = 2'd1,
    ACT_ABORT  = 2'd2,
    ACT_RAZWI  = 2'd3
  } action_e;

  localparam int CFG_DATA_W  = 32;
  localparam int MASK_LSB    = 16;
  localparam int CB_LSB      = 8;
  localparam int VALID_BIT   = 31;
  localparam int CTL_ABT_BIT = 0;
  localparam int CTL_BYP_BIT = 1;

endpackage

// File: rtl/sid_cfg_regs.sv
module sid_cfg_regs
  import sid_route_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ID_W      = 10,
  parameter int CB_W      = 6,
  parameter int ADDR_W    = 6,
  parameter int SPLIT_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic                            wsecure_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [CFG_DATA_W-1:0]           wdata_i,
  output logic [N_ENTRIES-1:0]            m_valid_o,
  output logic [N_ENTRIES-1:0][ID_W-1:0]  m_id_o,
  output logic [N_ENTRIES-1:0][ID_W-1:0]  m_mask_o,
  output logic [N_ENTRIES-1:0][1:0]       r_type_o,
  output logic [N_ENTRIES-1:0][CB_W-1:0]  r_cb_o,
  output logic                            abort_en_o,
  output logic                            miss_byp_o,
  output logic [SPLIT_W-1:0]              split_o
);

  localparam int CTL_ADDR   = 2 * N_ENTRIES;
  localparam int SPLIT_ADDR = CTL_ADDR + 1;

  logic               abort_en_q, miss_byp_q;
  logic [SPLIT_W-1:0] split_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  // globals: secure writes only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_en_q <= 1'b0;
      miss_byp_q <= 1'b0;
      split_q    <= '0;
    end else if (we_i && wsecure_i) begin
      if (addr_i == ADDR_W'(CTL_ADDR)) begin
        abort_en_q <= wdata_i[CTL_ABT_BIT];
        miss_byp_q <= wdata_i[CTL_BYP_BIT];
      end
      if (addr_i == ADDR_W'(SPLIT_ADDR)) split_q <= wdata_i[SPLIT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic            wr_ok;
    logic            v_q;
    logic [ID_W-1:0] id_q, mask_q;
    logic [1:0]      type_q;
    logic [CB_W-1:0] cb_q;

    // non-secure may only touch entries below the split
    assign wr_ok = we_i && (wsecure_i || (SPLIT_W'(g) < split_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q    <= 1'b0;
        id_q   <= '0;
        mask_q <= '0;
      end else if (wr_ok && addr_i == ADDR_W'(g)) begin
        v_q    <= wdata_i[VALID_BIT];
        mask_q <= wdata_i[MASK_LSB +: ID_W];
        id_q   <= wdata_i[ID_W-1:0];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        type_q <= 2'(RT_FAULT);
        cb_q   <= '0;
      end else if (wr_ok && addr_i == ADDR_W'(N_ENTRIES + g)) begin
        type_q <= wdata_i[1:0];
        cb_q   <= wdata_i[CB_LSB +: CB_W];
      end
    end

    assign m_valid_o[g] = v_q;
    assign m_id_o[g]    = id_q;
    assign m_mask_o[g]  = mask_q;
    assign r_type_o[g]  = type_q;
    assign r_cb_o[g]    = cb_q;
  end

  assign abort_en_o = abort_en_q;
  assign miss_byp_o = miss_byp_q;
  assign split_o    = split_q;

endmodule

// File: rtl/sid_match_array.sv
module sid_match_array #(
  parameter int N_ENTRIES = 16,
  parameter int ID_W      = 10,
  parameter int SPLIT_W   = 5
) (
  input  logic [ID_W-1:0]                 sid_i,
  input  logic                            secure_i,
  input  logic [SPLIT_W-1:0]              split_i,
  input  logic [N_ENTRIES-1:0]            m_valid_i,
  input  logic [N_ENTRIES-1:0][ID_W-1:0]  m_id_i,
  input  logic [N_ENTRIES-1:0][ID_W-1:0]  m_mask_i,
  output logic [N_ENTRIES-1:0]            hit_o
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic in_set, id_eq;
    assign in_set = secure_i ? (SPLIT_W'(g) >= split_i) : (SPLIT_W'(g) < split_i);
    assign id_eq  = ((sid_i ^ m_id_i[g]) & ~m_mask_i[g]) == '0;
    assign hit_o[g] = m_valid_i[g] && in_set && id_eq;
  end

endmodule

// File: rtl/sid_result_gen.sv
module sid_result_gen
  import sid_route_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CB_W      = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic [N_ENTRIES-1:0]            hit_i,
  input  logic [N_ENTRIES-1:0][1:0]       r_type_i,
  input  logic [N_ENTRIES-1:0][CB_W-1:0]  r_cb_i,
  input  logic                            abort_en_i,
  input  logic                            miss_byp_i,
  output logic                            res_valid_o,
  output logic [1:0]                      res_action_o,
  output logic [CB_W-1:0]                 res_cb_o,
  output logic                            res_imprecise_o,
  output logic [1:0]                      res_hits_o
);

  logic [1:0]      hits_d, sel_type, act_d;
  logic [CB_W-1:0] sel_cb, cb_d;
  logic            fault_d, impr_d;

  // saturating count plus OR-select; select is only used on a single hit
  always_comb begin
    hits_d   = '0;
    sel_type = '0;
    sel_cb   = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_i[i]) begin
        if (hits_d != 2'd2) hits_d = hits_d + 2'd1;
        sel_type = sel_type | r_type_i[i];
        sel_cb   = sel_cb | r_cb_i[i];
      end
    end
  end

  always_comb begin
    fault_d = 1'b0;
    impr_d  = 1'b0;
    act_d   = ACT_BYPASS;
    cb_d    = '0;
    unique case (hits_d)
      2'd0: fault_d = !miss_byp_i;
      2'd1: begin
        if (sel_type == RT_BYPASS) act_d = ACT_BYPASS;
        else if (sel_type == RT_XLATE) begin
          act_d = ACT_XLATE;
          cb_d  = sel_cb;
        end else fault_d = 1'b1;
      end
      default: begin
        fault_d = 1'b1;
        impr_d  = 1'b1;
      end
    endcase
    if (fault_d) act_d = abort_en_i ? ACT_ABORT : ACT_RAZWI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o     <= 1'b0;
      res_action_o    <= '0;
      res_cb_o        <= '0;
      res_imprecise_o <= 1'b0;
      res_hits_o      <= '0;
    end else begin
      res_valid_o     <= req_valid_i;
      res_action_o    <= req_valid_i ? act_d  : '0;
      res_cb_o        <= req_valid_i ? cb_d   : '0;
      res_imprecise_o <= req_valid_i && impr_d;
      res_hits_o      <= req_valid_i ? hits_d : '0;
    end
  end

endmodule

// File: rtl/sid_route_unit.sv
module sid_route_unit
  import sid_route_pkg::*;
#(
  parameter  int N_ENTRIES = 16,
  parameter  int ID_W      = 10,
  parameter  int CB_W      = 6,
  localparam int ADDR_W    = $clog2(2 * N_ENTRIES + 2),
  localparam int SPLIT_W   = $clog2(N_ENTRIES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic                  cfg_secure_i,
  input  logic [ADDR_W-1:0]     cfg_addr_i,
  input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
  input  logic                  req_valid_i,
  input  logic                  req_secure_i,
  input  logic [ID_W-1:0]       req_sid_i,
  output logic                  res_valid_o,
  output logic [1:0]            res_action_o,
  output logic [CB_W-1:0]       res_cb_o,
  output logic                  res_imprecise_o,
  output logic [1:0]            res_hits_o
);

  logic [N_ENTRIES-1:0]            m_valid, hit;
  logic [N_ENTRIES-1:0][ID_W-1:0]  m_id, m_mask;
  logic [N_ENTRIES-1:0][1:0]       r_type;
  logic [N_ENTRIES-1:0][CB_W-1:0]  r_cb;
  logic                            abort_en, miss_byp;
  logic [SPLIT_W-1:0]              split;

  sid_cfg_regs #(
    .N_ENTRIES(N_ENTRIES), .ID_W(ID_W), .CB_W(CB_W),
    .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wsecure_i  (cfg_secure_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .m_valid_o  (m_valid),
    .m_id_o     (m_id),
    .m_mask_o   (m_mask),
    .r_type_o   (r_type),
    .r_cb_o     (r_cb),
    .abort_en_o (abort_en),
    .miss_byp_o (miss_byp),
    .split_o    (split)
  );

  sid_match_array #(
    .N_ENTRIES(N_ENTRIES), .ID_W(ID_W), .SPLIT_W(SPLIT_W)
  ) u_match (
    .sid_i     (req_sid_i),
    .secure_i  (req_secure_i),
    .split_i   (split),
    .m_valid_i (m_valid),
    .m_id_i    (m_id),
    .m_mask_i  (m_mask),
    .hit_o     (hit)
  );

  sid_result_gen #(
    .N_ENTRIES(N_ENTRIES), .CB_W(CB_W)
  ) u_res (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .hit_i           (hit),
    .r_type_i        (r_type),
    .r_cb_i          (r_cb),
    .abort_en_i      (abort_en),
    .miss_byp_i      (miss_byp),
    .res_valid_o     (res_valid_o),
    .res_action_o    (res_action_o),
    .res_cb_o        (res_cb_o),
    .res_imprecise_o (res_imprecise_o),
    .res_hits_o      (res_hits_o)
  );

endmodule

// File: rtl/sid_route_chk.sv
module sid_route_chk
  import sid_route_pkg::*;
#(
  parameter int CB_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            res_valid_i,
  input logic [1:0]      res_action_i,
  input logic [CB_W-1:0] res_cb_i,
  input logic            res_imprecise_i,
  input logic [1:0]      res_hits_i,
  input logic            abort_en_i
);

  // R10
  req_to_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_i);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!res_valid_i && res_action_i == 2'd0 && res_cb_i == '0
                      && !res_imprecise_i && res_hits_i == 2'd0));

  // R6
  imprecise_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_imprecise_i |-> (res_hits_i == 2'd2 &&
                         (res_action_i == ACT_ABORT || res_action_i == ACT_RAZWI)));

  // R6
  hits_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> res_hits_i != 2'd3);

  // R4
  cb_only_xlate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_action_i != ACT_XLATE) |-> res_cb_i == '0);

  // R7
  abort_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_action_i == ACT_ABORT) |-> $past(abort_en_i));

  // R7
  razwi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_action_i == ACT_RAZWI) |-> !$past(abort_en_i));

endmodule

bind sid_route_unit sid_route_chk #(.CB_W(CB_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .res_valid_i     (res_valid_o),
  .res_action_i    (res_action_o),
  .res_cb_i        (res_cb_o),
  .res_imprecise_i (res_imprecise_o),
  .res_hits_i      (res_hits_o),
  .abort_en_i      (abort_en)
);

// File: tb/sid_route_unit_tb_top.sv
module sid_route_unit_tb_top;

  localparam int N    = 16;
  localparam int ID_W = 10;
  localparam int CB_W = 6;
  localparam int AW   = 6;
  localparam int RW   = 1 + 2 + CB_W + 1 + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0, cfg_sec = 1'b0;
  logic [AW-1:0]   cfg_addr = '0;
  logic [31:0]     cfg_wdata = '0;
  logic            req_valid = 1'b0, req_sec = 1'b0;
  logic [ID_W-1:0] req_sid = '0;
  logic            res_valid, res_impr;
  logic [1:0]      res_action, res_hits;
  logic [CB_W-1:0] res_cb;

  always #2ns clk = ~clk;

  sid_route_unit #(.N_ENTRIES(N), .ID_W(ID_W), .CB_W(CB_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_secure_i(cfg_sec), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_secure_i(req_sec), .req_sid_i(req_sid),
    .res_valid_o(res_valid), .res_action_o(res_action), .res_cb_o(res_cb),
    .res_imprecise_o(res_impr), .res_hits_o(res_hits)
  );

  // behavioural model state
  bit    mv[N];
  int    mid[N], mmask[N], rtyp[N], rcb[N];
  bit    ae, ub;
  int    split;
  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";

  function automatic void model_write(bit sec, int a, logic [31:0] d);
    if (a < N) begin
      if (sec || a < split) begin
        mv[a] = d[31]; mmask[a] = int'(d[25:16]); mid[a] = int'(d[9:0]);
      end
    end else if (a < 2 * N) begin
      if (sec || (a - N) < split) begin
        rtyp[a - N] = int'(d[1:0]); rcb[a - N] = int'(d[13:8]);
      end
    end else if (a == 2 * N && sec) begin
      ae = d[0]; ub = d[1];
    end else if (a == 2 * N + 1 && sec) begin
      split = int'(d[4:0]);
    end
  endfunction

  task automatic compare(logic [RW-1:0] exp_v);
    logic [RW-1:0] got;
    got = {res_valid, res_action, res_cb, res_impr, res_hits};
    n_cmp++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h (valid,action,cb,imprecise,hits)", tag, got, exp_v);
    end
  endtask

  // one clock: predict from pre-edge state, then apply any write
  task automatic step();
    logic [RW-1:0] exp_v;
    int nh, idx, act, cb, hv;
    bit flt, imp;
    exp_v = '0;
    if (req_valid) begin
      nh = 0; idx = 0; flt = 0; imp = 0; act = 0; cb = 0;
      for (int i = 0; i < N; i++) begin
        bit inp;
        inp = req_sec ? (i >= split) : (i < split);
        if (mv[i] && inp && (((int'(req_sid) ^ mid[i]) & ~mmask[i] & 'h3FF) == 0)) begin
          nh++; idx = i;
        end
      end
      if (nh == 0) begin
        if (ub) act = 0; else flt = 1;
      end else if (nh > 1) begin
        flt = 1; imp = 1;
      end else begin
        if (rtyp[idx] == 1) act = 0;
        else if (rtyp[idx] == 2) begin act = 1; cb = rcb[idx]; end
        else flt = 1;
      end
      if (flt) act = ae ? 2 : 3;
      hv = (nh > 2) ? 2 : nh;
      exp_v = {1'b1, 2'(act), CB_W'(cb), imp, 2'(hv)};
    end
    if (cfg_we) model_write(cfg_sec, int'(cfg_addr), cfg_wdata);
    @(posedge clk);
    #1ns;
    compare(exp_v);
  endtask

  task automatic wr(bit sec, int a, logic [31:0] d);
    cfg_we = 1'b1; cfg_sec = sec; cfg_addr = AW'(a); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rq(bit sec, int sid);
    req_valid = 1'b1; req_sec = sec; req_sid = ID_W'(sid);
    step();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mid[i] = 0; mmask[i] = 0; rtyp[i] = 0; rcb[i] = 0;
    end
    ae = 0; ub = 0; split = 0;
    repeat (3) @(posedge clk);
    #1ns;
    rst_n = 1'b1;

    tag = "R1";
    compare('0);
    step();
    rq(0, 'h155);
    rq(1, 'h155);

    tag = "R7";
    wr(1, 2 * N, 32'h1);
    rq(1, 'h155);

    tag = "R5";
    wr(1, 2 * N, 32'h3);
    rq(0, 'h003);

    tag = "R11";
    wr(1, 2 * N + 1, 32'd8);
    wr(0, 2, 32'h8000_0155);
    wr(0, N + 2, (32'd5 << 8) | 32'd2);

    tag = "R4";
    rq(0, 'h155);

    tag = "R8";
    rq(1, 'h155);

    tag = "R2";
    wr(0, 3, 32'h800F_0200);
    wr(0, N + 3, 32'h1);
    rq(0, 'h20A);
    rq(0, 'h21A);

    tag = "R6";
    wr(0, 4, 32'h800F_0150);
    wr(0, N + 4, (32'd7 << 8) | 32'd2);
    rq(0, 'h155);
    wr(0, 5, 32'h80FF_0100);
    rq(0, 'h155);
    wr(1, 2 * N, 32'h2);
    rq(0, 'h155);

    tag = "R9";
    wr(0, 10, 32'h8000_00AA);
    rq(1, 'h0AA);
    wr(1, 10, 32'h8000_00AA);
    wr(1, N + 10, 32'h0);
    rq(1, 'h0AA);
    rq(0, 'h0AA);
    wr(0, 2 * N, 32'h1);
    rq(0, 'h3FF);
    wr(0, 2 * N + 1, 32'd16);
    rq(1, 'h0AA);

    tag = "R3";
    wr(0, N + 3, 32'h3);
    rq(0, 'h20A);
    wr(0, N + 3, 32'h1);
    rq(0, 'h20A);

    tag = "R2";
    wr(0, 3, 32'h000F_0200);
    rq(0, 'h20A);

    tag = "R10";
    req_valid = 1'b1; req_sec = 1'b0;
    req_sid = ID_W'('h155); step();
    req_sid = ID_W'('h2AA); step();
    req_sec = 1'b1; req_sid = ID_W'('h0AA); step();
    req_valid = 1'b0; step();
    req_valid = 1'b1; req_sec = 1'b0; req_sid = ID_W'('h155);
    cfg_we = 1'b1; cfg_sec = 1'b0; cfg_addr = AW'(2); cfg_wdata = 32'h0;
    step();
    cfg_we = 1'b0; step();
    req_valid = 1'b0; step();

    tag = "R8";
    wr(0, 2, 32'h8000_0155);
    wr(1, 2 * N + 1, 32'd16);
    rq(1, 'h0AA);
    rq(0, 'h0AA);
    wr(1, 2 * N + 1, 32'd0);
    rq(0, 'h155);
    rq(1, 'h155);
    wr(1, 2 * N + 1, 32'd20);
    rq(0, 'h155);

    tag = "R8 random";
    for (int c = 0; c < 1500; c++) begin
      cfg_we = ($urandom_range(0, 9) < 3);
      cfg_sec = 1'($urandom_range(0, 1));
      cfg_addr = AW'($urandom_range(0, 2 * N + 1));
      cfg_wdata = $urandom;
      if (int'(cfg_addr) < N) begin
        cfg_wdata[9:0] = 10'($urandom_range(0, 7));
        cfg_wdata[25:16] = 10'($urandom_range(0, 3));
      end else if (int'(cfg_addr) == 2 * N + 1) begin
        cfg_wdata[4:0] = 5'($urandom_range(0, 18));
      end
      req_valid = 1'($urandom_range(0, 3) != 0);
      req_sec = 1'($urandom_range(0, 1));
      req_sid = ID_W'($urandom_range(0, 9));
      step();
    end
    cfg_we = 1'b0; req_valid = 1'b0;
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule